// File: doc/BRIEF.md
# Triangular Bit-Skew Delay Network

This block gives each bit of a parallel word its own latency. In the default skew arrangement, bit k of the output is bit k of the input as it was k clock cycles earlier. Bit 0 passes straight through without a register, and the top bit waits WIDTH-1 cycles. The main use is to stagger operand bits so that they meet the carry as it ripples through a bit-level pipelined phase accumulator, where one carry stage is added per bit.

A parameter sets the orientation. In deskew mode, lane k is delayed by WIDTH-1-k cycles. A result that left a bit-pipelined datapath skewed can then be brought back into one aligned word. Every lane is a private chain of single-bit registers exactly as long as its delay, so the storage forms a triangle of WIDTH*(WIDTH-1)/2 flops. An asynchronous active-low reset empties every chain.

Top module: `bitskew_net`

## Requirements
- R1: With MODE set to skew (encoding 0), output bit k at any cycle equals input bit k as it was k rising clock edges earlier, for every k from 0 to WIDTH-1.
- R2: With MODE set to deskew (encoding 1), output bit k equals input bit k as it was WIDTH-1-k rising clock edges earlier.
- R3: Driving rst_n low clears every register of every lane at once, without waiting for a clock edge. While rst_n is low, each lane whose delay is at least one outputs 0.
- R4: After rst_n is released, a lane with delay d outputs 0 for its first d clock edges, then shows the input bit taken at or after the release.
- R5: The lane whose delay is zero (bit 0 in skew mode, bit WIDTH-1 in deskew mode) is a combinational path from input to output, with zero latency, also during reset.
- R6: Lanes are independent single-bit serial chains. A value moves one stage per clock edge, the number of ones held in a lane changes by at most one per edge, and a change on input bit k reaches only output bit k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all lane registers |
| rst_n | input | 1 | Asynchronous reset, active low; empties all lanes |
| din | input | WIDTH | Aligned input word; bit k feeds lane k |
| dout | output | WIDTH | Skewed (or deskewed) output word; bit k is the tail of lane k |

## Verification
On every clock edge, the embedded assertions check three things: the output of a lane still filling after reset stays at zero, the occupancy of each chain steps by at most one, and the lanes are empty at the first edge after reset. For single-stage lanes they also check the port-level one-cycle delay. The exact per-lane latency across a long chain can only be shown by the bench scenarios. These are an exhaustive sweep of all input words for a 6-bit skew instance and a 5-bit deskew instance, random streams, a mid-stream asynchronous reset with an immediate output check, and a walking-one pattern that shows the lanes do not disturb each other.

// File: rtl/skew_pkg.sv
package skew_pkg;

    typedef enum logic {
        MODE_SKEW   = 1'b0,
        MODE_DESKEW = 1'b1
    } skew_mode_e;

    // Number of register stages in a given lane.
    function automatic int unsigned lane_delay(
        input int unsigned lane,
        input int unsigned width,
        input skew_mode_e  mode
    );
        if (mode == MODE_SKEW) begin
            return lane;
        end
        return width - 1 - lane;
    endfunction

    // Index of the lane that carries no register.
    function automatic int unsigned pass_lane(
        input int unsigned width,
        input skew_mode_e  mode
    );
        return (mode == MODE_SKEW) ? 0 : width - 1;
    endfunction

    // Total flop count of the triangle.
    function automatic int unsigned triangle_flops(input int unsigned width);
        return (width * (width - 1)) / 2;
    endfunction

endpackage

// File: rtl/skew_lane.sv
module skew_lane #(
    parameter int unsigned DEPTH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int unsigned AW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= din;
            for (int j = 1; j < int'(DEPTH); j++) begin
                chain[j] <= chain[j-1];
            end
        end
    end

    assign dout = chain[DEPTH-1];

    // Edges seen since reset release, saturating at DEPTH; used by checks.
    logic [AW-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != AW'(DEPTH)) begin
            age <= age + 1'b1;
        end
    end

    AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (age < AW'(DEPTH)) |-> (dout == 1'b0)); // R4

    AST_LANE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chain == '0)); // R3

    AST_OCCUPANCY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (($countones(chain) <= $past($countones(chain)) + 1) &&
         ($past($countones(chain)) <= $countones(chain) + 1))); // R6

    generate
        if (DEPTH == 1) begin : g_unit
            AST_UNIT_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
                (age == AW'(DEPTH)) |-> (dout == $past(din))); // R1
        end
    endgenerate

endmodule

// File: rtl/skew_bank.sv
module skew_bank
    import skew_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter skew_mode_e  MODE  = MODE_SKEW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned FLOPS = triangle_flops(WIDTH);
    localparam int unsigned ZLANE = pass_lane(WIDTH, MODE);

    generate
        for (genvar k = 0; k < int'(WIDTH); k++) begin : g_lane
            localparam int unsigned D = lane_delay(k, WIDTH, MODE);
            if (D == 0) begin : g_pass
                assign dout[k] = din[k];
            end else begin : g_reg
                skew_lane #(.DEPTH(D)) u_lane (
                    .clk  (clk),
                    .rst_n(rst_n),
                    .din  (din[k]),
                    .dout (dout[k])
                );
            end
        end
    endgenerate

    initial begin
        if (FLOPS == 0 || ZLANE >= WIDTH) begin
            $display("skew_bank: WIDTH must be at least 2");
        end
    end

endmodule

// File: rtl/bitskew_net.sv
module bitskew_net
    import skew_pkg::*;
#(
    parameter int unsigned WIDTH = 32,
    parameter skew_mode_e  MODE  = MODE_SKEW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    skew_bank #(
        .WIDTH(WIDTH),
        .MODE (MODE)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (din),
        .dout (dout)
    );

endmodule

// File: tb/bitskew_net_test.sv
module bitskew_net_test;
    localparam int CLK_PERIOD = 10;
    localparam int WA = 6;
    localparam int WB = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [WA-1:0] din_a = '0;
    logic [WA-1:0] dout_a;
    logic [WB-1:0] din_b = '0;
    logic [WB-1:0] dout_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitskew_net #(.WIDTH(WA), .MODE(skew_pkg::MODE_SKEW)) uut (
        .clk(clk), .rst_n(rst_n), .din(din_a), .dout(dout_a));

    bitskew_net #(.WIDTH(WB), .MODE(skew_pkg::MODE_DESKEW)) uut_dsk (
        .clk(clk), .rst_n(rst_n), .din(din_b), .dout(dout_b));

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int t = 0;
    int t_rel = 0;
    logic [WA-1:0] hist [0:2047];

    task automatic cmp(input string req, input int lane, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s lane %0d step %0d: got %b expected %b", req, lane, t, got, exp);
        end
    endtask

    task automatic check_all(input bit walk);
        for (int k = 0; k < WA; k++) begin
            int d = k;
            logic e = (t - d >= t_rel) ? hist[t-d][k] : 1'b0;
            string r = walk ? "R6" : (d == 0) ? "R5" : (t - d < t_rel) ? "R4" : "R1";
            cmp(r, k, dout_a[k], e);
        end
        for (int k = 0; k < WB; k++) begin
            int d = WB - 1 - k;
            logic e = (t - d >= t_rel) ? hist[t-d][k] : 1'b0;
            string r = walk ? "R6" : (d == 0) ? "R5" : (t - d < t_rel) ? "R4" : "R2";
            cmp(r, k, dout_b[k], e);
        end
    endtask

    task automatic step(input logic [WA-1:0] v, input bit walk);
        @(negedge clk);
        din_a = v;
        din_b = v[WB-1:0];
        hist[t] = v;
        #1;
        check_all(walk);
        t++;
    endtask

    // R3: delayed lanes are zero while reset is held
    task automatic check_reset_zero();
        for (int k = 1; k < WA; k++) cmp("R3", k, dout_a[k], 1'b0);
        for (int k = 0; k < WB - 1; k++) cmp("R3", k, dout_b[k], 1'b0);
        cmp("R5", WB - 1, dout_b[WB-1], din_b[WB-1]);
    endtask

    task automatic release_reset();
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_rel = t;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        din_a = 6'b111111;
        din_b = 5'b11111;
        repeat (3) @(posedge clk);
        #1;
        check_reset_zero();
        release_reset();

        // exhaustive sweep of every input word
        for (int v = 0; v < (1 << WA); v++) step(WA'(v), 1'b0);
        // descending sweep
        for (int v = (1 << WA) - 1; v >= 0; v--) step(WA'(v), 1'b0);
        // random stream
        for (int i = 0; i < 300; i++) step(WA'($urandom), 1'b0);

        // asynchronous mid-stream reset, checked without a clock edge
        #1;
        rst_n = 1'b0;
        #1;
        check_reset_zero();
        repeat (2) @(posedge clk);
        release_reset();
        for (int i = 0; i < 150; i++) step(WA'($urandom), 1'b0);

        // walking one for lane isolation
        for (int r = 0; r < 2; r++) begin
            for (int k = 0; k < WA; k++) begin
                step(WA'(1) << k, 1'b1);
                for (int z = 0; z < WA; z++) step('0, 1'b1);
            end
        end
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule